// File: doc/BRIEF.md
# Two-Format Serial Audio Receiver

This block is the receive side of a two-channel serial audio link in which an external source owns all timing. The source supplies a bit clock, a frame clock running at the sample rate and a serial data line. The block samples all three with a faster system clock, finds the rising edges of the bit clock, and puts together one left and one right PCM word per frame. It never drives a clock.

Two bit alignments are supported, picked by a format select input. In the delayed-MSB format the first data bit follows a frame-clock change by one bit period, and a low frame clock marks the left channel. In the immediate-MSB format the first data bit falls on the bit period in which the frame clock changes, and a high frame clock marks the left channel. One word-assembly path serves both. The control decides on every frame-clock change where the next word begins and which channel it belongs to. Each finished stereo pair appears on two parallel outputs together with a one-cycle strobe.

Top module: `serial_audio_rx`

## Requirements
- R1: While reset is held and after it is released, `leftSample` and `rightSample` are zero and `sampleValid` is low until the first pair is delivered.
- R2: With `fmtSel` = 0 (delayed-MSB), bits are sampled on bit-clock rising edges, the MSB of a word is the bit sampled one bit period after a frame-clock change, and a low frame clock marks the left channel.
- R3: With `fmtSel` = 1 (immediate-MSB), the MSB of a word is the bit sampled in the first bit period after a frame-clock change, and a high frame clock marks the left channel.
- R4: Words are assembled MSB first. When a half-frame carries more bits than `WORD_LEN`, the first `WORD_LEN` bits form the sample and the rest are ignored.
- R5: When a half-frame carries fewer bits than `WORD_LEN`, the received bits fill the upper part of the sample and the low bits are zero.
- R6: `sampleValid` is a pulse of one system clock. It is raised once per stereo pair, after the right half-frame ends, and both sample outputs update in that same cycle.
- R7: The frame in progress when reset is released, which has no observed left-channel start, yields no pulse.
- R8: `fmtSel` is taken only at a frame-clock change. A change of `fmtSel` that is undone before the next frame-clock change has no effect. When the format does change, the pair cut by the change and the first new-format frame yield no pulse.
- R9: Between pulses, `leftSample` and `rightSample` hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the bit clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitClk | input | 1 | Serial bit clock from the source |
| frameClk | input | 1 | Frame clock from the source, one period per sample |
| serData | input | 1 | Serial data, sampled on bit-clock rising edges |
| fmtSel | input | 1 | 0 = delayed-MSB alignment, 1 = immediate-MSB alignment |
| leftSample | output | WORD_LEN | Last delivered left-channel word |
| rightSample | output | WORD_LEN | Last delivered right-channel word |
| sampleValid | output | 1 | One-cycle strobe that marks a new stereo pair |

## Verification
The bench builds the block with `WORD_LEN` = 20 and two synchronizer stages, and runs the bit clock at one eighth of the system clock. With a 20-bit word, the same stimulus can send half-frames of 16 bits (padded), 20 bits (exact) and 24 or 32 bits (truncated), plus random lengths between those. Both alignments are covered, with format switches in each direction. A brief format glitch inside a half-frame shows that only the value seen at a frame-clock change counts.

// File: rtl/sar_pkg.sv
package sar_pkg;

  localparam bit FMT_DELAYED   = 1'b0;
  localparam bit FMT_IMMEDIATE = 1'b1;

  typedef struct packed {
    logic startHalf;
    logic writeBit;
    logic finishLeft;
    logic emitPair;
  } sarStrobes_t;

endpackage

// File: rtl/sar_sync.sv
module sar_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] stageQ [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rstN) begin
        stageQ[s] <= '0;
      end else if (s == 0) begin
        stageQ[s] <= asyncIn;
      end else begin
        stageQ[s] <= stageQ[(s == 0) ? 0 : s-1];
      end
    end
  end

  assign syncOut = stageQ[STAGES-1];

endmodule

// File: rtl/sar_ctrl.sv
module sar_ctrl
  import sar_pkg::*;
#(
  parameter int WORD_LEN = 24,
  localparam int CW = $clog2(WORD_LEN + 1)
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        bitClkS,
  input  logic        frameS,
  input  logic        fmtS,
  output sarStrobes_t strobes,
  output logic [CW-1:0] bitIdx
);

  logic bitClkPrev;
  logic seenBit;
  logic prevFrame;
  logic fmtReg;
  logic pendStart;
  logic pendLeft;
  logic curLeft;
  logic curGood;
  logic leftGood;
  logic [CW-1:0] bitCnt;

  logic bitTick, transition, fmtNext, fmtChange;
  logic quickStart, startNow, newLeft, halfGood, roomLeft;

  always_comb begin
    bitTick    = bitClkS && !bitClkPrev;
    transition = seenBit && (frameS != prevFrame);
    fmtNext    = transition ? fmtS : fmtReg;
    fmtChange  = transition && (fmtS != fmtReg);
    quickStart = transition && (fmtNext == FMT_IMMEDIATE);
    startNow   = quickStart || pendStart;
    newLeft    = (fmtNext == FMT_IMMEDIATE) ? frameS : !frameS;
    halfGood   = curGood && !fmtChange;
    roomLeft   = bitCnt < CW'(WORD_LEN);

    strobes.startHalf  = bitTick && startNow;
    strobes.writeBit   = bitTick && !startNow && roomLeft;
    strobes.finishLeft = bitTick && startNow && curLeft && halfGood;
    strobes.emitPair   = bitTick && startNow && !curLeft && halfGood && leftGood;
    bitIdx             = bitCnt;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitClkPrev <= 1'b0;
      seenBit    <= 1'b0;
      prevFrame  <= 1'b0;
      fmtReg     <= FMT_DELAYED;
      pendStart  <= 1'b0;
      pendLeft   <= 1'b0;
      curLeft    <= 1'b0;
      curGood    <= 1'b0;
      leftGood   <= 1'b0;
      bitCnt     <= '0;
    end else begin
      bitClkPrev <= bitClkS;
      if (bitTick) begin
        seenBit   <= 1'b1;
        prevFrame <= frameS;
        fmtReg    <= fmtNext;
        pendStart <= transition && (fmtNext == FMT_DELAYED);
        if (transition) begin
          pendLeft <= newLeft;
        end
        if (fmtChange) begin
          curGood  <= 1'b0;
          leftGood <= 1'b0;
        end
        if (startNow) begin
          curLeft  <= quickStart ? newLeft : pendLeft;
          curGood  <= 1'b1;
          leftGood <= curLeft && halfGood;
          bitCnt   <= CW'(1);
        end else if (roomLeft) begin
          bitCnt <= bitCnt + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/sar_datapath.sv
module sar_datapath
  import sar_pkg::*;
#(
  parameter int WORD_LEN = 24,
  localparam int CW = $clog2(WORD_LEN + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  sarStrobes_t         strobes,
  input  logic [CW-1:0]       bitIdx,
  input  logic                serS,
  output logic [WORD_LEN-1:0] leftSample,
  output logic [WORD_LEN-1:0] rightSample,
  output logic                sampleValid
);

  logic [WORD_LEN-1:0] word;
  logic [WORD_LEN-1:0] leftHold;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      word        <= '0;
      leftHold    <= '0;
      leftSample  <= '0;
      rightSample <= '0;
      sampleValid <= 1'b0;
    end else begin
      sampleValid <= 1'b0;
      if (strobes.startHalf) begin
        word <= {serS, {(WORD_LEN-1){1'b0}}};
      end else if (strobes.writeBit) begin
        for (int i = 0; i < WORD_LEN; i++) begin
          if (bitIdx == CW'(WORD_LEN - 1 - i)) begin
            word[i] <= serS;
          end
        end
      end
      if (strobes.finishLeft) begin
        leftHold <= word;
      end
      if (strobes.emitPair) begin
        leftSample  <= leftHold;
        rightSample <= word;
        sampleValid <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
  import sar_pkg::*;
#(
  parameter int WORD_LEN    = 24,
  parameter int SYNC_STAGES = 2,
  localparam int CW = $clog2(WORD_LEN + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                bitClk,
  input  logic                frameClk,
  input  logic                serData,
  input  logic                fmtSel,
  output logic [WORD_LEN-1:0] leftSample,
  output logic [WORD_LEN-1:0] rightSample,
  output logic                sampleValid
);

  logic [3:0]    syncVec;
  sarStrobes_t   ctrlStb;
  logic [CW-1:0] bitIdx;

  sar_sync #(.WIDTH(4), .STAGES(SYNC_STAGES)) i_sync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn ({fmtSel, serData, frameClk, bitClk}),
    .syncOut (syncVec)
  );

  sar_ctrl #(.WORD_LEN(WORD_LEN)) i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .bitClkS (syncVec[0]),
    .frameS  (syncVec[1]),
    .fmtS    (syncVec[3]),
    .strobes (ctrlStb),
    .bitIdx  (bitIdx)
  );

  sar_datapath #(.WORD_LEN(WORD_LEN)) i_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (ctrlStb),
    .bitIdx      (bitIdx),
    .serS        (syncVec[2]),
    .leftSample  (leftSample),
    .rightSample (rightSample),
    .sampleValid (sampleValid)
  );

endmodule

// File: rtl/sar_checker.sv
module sar_checker #(
  parameter int WORD_LEN = 24
) (
  input logic                clk,
  input logic                rstN,
  input logic                frameClk,
  input logic                sampleValid,
  input logic [WORD_LEN-1:0] leftSample,
  input logic [WORD_LEN-1:0] rightSample
);

  logic       framePrev;
  logic [1:0] edgeCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      framePrev <= frameClk;
      edgeCnt   <= '0;
    end else begin
      framePrev <= frameClk;
      if (frameClk != framePrev && edgeCnt != 2'd3) begin
        edgeCnt <= edgeCnt + 2'd1;
      end
    end
  end

  // R1: the strobe is low in the cycle after any reset cycle
  a_r1_reset_quiet: assert property (@(posedge clk) !rstN |=> !sampleValid);

  // R6: strobe lasts exactly one system clock
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |=> !sampleValid);

  // R9: samples hold between strobes
  a_r9_hold: assert property (@(posedge clk) disable iff (!rstN)
    !sampleValid |-> ($stable(leftSample) && $stable(rightSample)));

  // R7: a pair needs a left start, a right start and a closing change after reset
  a_r7_no_early: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |-> edgeCnt == 2'd3);

endmodule

bind serial_audio_rx sar_checker #(.WORD_LEN(WORD_LEN)) i_sarChecker (
  .clk         (clk),
  .rstN        (rstN),
  .frameClk    (frameClk),
  .sampleValid (sampleValid),
  .leftSample  (leftSample),
  .rightSample (rightSample)
);

// File: tb/test_serial_audio_rx.sv
module test_serial_audio_rx;

  localparam int  W          = 20;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bitClk = 1'b0;
  logic frameClk = 1'b1;
  logic serData = 1'b0;
  logic fmtSel = 1'b1;
  logic [W-1:0] leftSample, rightSample;
  logic sampleValid;

  int nChecks = 0;
  int nErrors = 0;
  logic carryBit = 1'b0;
  logic [W-1:0] expL[$];
  logic [W-1:0] expR[$];
  string expTag[$];
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_audio_rx #(.WORD_LEN(W), .SYNC_STAGES(2)) i_serial_audio_rx (
    .clk(clk), .rstN(rstN), .bitClk(bitClk), .frameClk(frameClk),
    .serData(serData), .fmtSel(fmtSel), .leftSample(leftSample),
    .rightSample(rightSample), .sampleValid(sampleValid)
  );

  function automatic logic [W-1:0] expWord(input logic [31:0] d, input int h);
    logic [63:0] m;
    m = {32'd0, d} & ((64'd1 << h) - 64'd1);
    if (h >= W) return W'(m >> (h - W));
    return W'(m << (W - h));
  endfunction

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic slot(input logic fr, input logic b);
    @(negedge clk);
    bitClk = 1'b0; frameClk = fr; serData = b;
    repeat (4) @(negedge clk);
    bitClk = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // fmt 1: immediate MSB, left = high; fmt 0: delayed MSB, left = low
  task automatic sendFrame(input logic fmt, input int h, input logic [31:0] l,
                           input logic [31:0] r, input bit expect_, input string tag,
                           input bit glitch);
    for (int half = 0; half < 2; half++) begin
      logic [31:0] d;
      logic lvl;
      d   = (half == 0) ? l : r;
      lvl = (half == 0) ? fmt : !fmt;
      for (int i = 0; i < h; i++) begin
        logic b;
        if (glitch && half == 0 && i == 2) fmtSel = !fmt;
        if (glitch && half == 0 && i == h - 3) fmtSel = fmt;
        if (fmt) b = d[h-1-i];
        else b = (i == 0) ? carryBit : d[h-i];
        slot(lvl, b);
      end
      carryBit = d[0];
    end
    if (expect_) begin
      expL.push_back(expWord(l, h));
      expR.push_back(expWord(r, h));
      expTag.push_back(tag);
    end
  endtask

  always @(negedge clk) begin
    if (rstN && sampleValid) begin
      if (expL.size() == 0) begin
        nChecks++; nErrors++;
        $display("FAIL R7/R8 unexpected pulse actual L=%h R=%h expected none",
                 leftSample, rightSample);
      end else begin
        string t;
        t = expTag.pop_front();
        check({t, " left"},  leftSample,  expL.pop_front());
        check({t, " right"}, rightSample, expR.pop_front());
      end
    end
  end

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nErrors++;
    $display("FAIL watchdog actual=running expected=finished");
    finishRun();
  end

  initial begin
    int seedDummy;
    int n;
    seedDummy = $urandom(32'h5A17);
    repeat (5) @(negedge clk);
    // R1: outputs during and after reset
    check("R1 valid in reset", W'(sampleValid), '0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 left after reset", leftSample, '0);
    check("R1 right after reset", rightSample, '0);
    check("R1 valid after reset", W'(sampleValid), '0);

    // R7: first frame after reset is not delivered; R3 immediate-MSB frames follow
    sendFrame(1'b1, W, $urandom, $urandom, 1'b0, "R7", 1'b0);
    sendFrame(1'b1, W, 32'hABCDE, 32'h12345, 1'b1, "R3 fixed", 1'b0);
    sendFrame(1'b1, 24, 32'hFEDCBA, 32'h0F0F0F, 1'b1, "R3 R4 long", 1'b0);
    sendFrame(1'b1, 16, 32'hBEEF, 32'h8001, 1'b1, "R3 R5 short", 1'b0);
    for (int k = 0; k < 4; k++) begin
      n = 16 + int'($urandom % 17);
      sendFrame(1'b1, n, $urandom, $urandom, 1'b1, "R3 random", 1'b0);
    end
    // R8: last frame before a format switch is dropped
    sendFrame(1'b1, W, $urandom, $urandom, 1'b0, "R8", 1'b0);

    fmtSel = 1'b0;
    sendFrame(1'b0, W, $urandom, $urandom, 1'b0, "R8", 1'b0);
    sendFrame(1'b0, W, 32'h80001, 32'h7FFFE, 1'b1, "R2 fixed", 1'b0);
    sendFrame(1'b0, 32, 32'hDEADBEEF, 32'hCAFEF00D, 1'b1, "R2 R4 long", 1'b0);
    sendFrame(1'b0, 16, 32'hFFFF, 32'h0001, 1'b1, "R2 R5 short", 1'b0);
    sendFrame(1'b0, 24, $urandom, $urandom, 1'b1, "R8 glitch ignored", 1'b1);
    for (int k = 0; k < 4; k++) begin
      n = 16 + int'($urandom % 17);
      sendFrame(1'b0, n, $urandom, $urandom, 1'b1, "R2 random", 1'b0);
    end
    sendFrame(1'b0, W, $urandom, $urandom, 1'b0, "R8", 1'b0);

    fmtSel = 1'b1;
    sendFrame(1'b1, W, $urandom, $urandom, 1'b0, "R8", 1'b0);
    for (int k = 0; k < 3; k++) begin
      n = 16 + int'($urandom % 17);
      sendFrame(1'b1, n, $urandom, $urandom, 1'b1, "R8 after switch", 1'b0);
    end
    // closing frame lets the last expected pair out
    sendFrame(1'b1, W, $urandom, $urandom, 1'b0, "flush", 1'b0);
    repeat (20) @(negedge clk);

    // R6: every expected pair was delivered exactly once
    nChecks++;
    if (expL.size() != 0) begin
      nErrors++;
      $display("FAIL R6 pending pairs actual=%0d expected=0", expL.size());
    end
    finishRun();
  end

endmodule